// File: doc/BRIEF.md
# SPI Slave Burst Register Bridge

This block lets an external SPI master read and write a bank of 32-bit registers held inside the chip. The master pulls the active-low select line down, clocks in a one-byte operation code, then a one-byte start address, and then streams any number of 32-bit words. Every field travels least significant bit first. After each word the address moves on by four, so a burst walks through consecutive registers and wraps at the end of the 8-bit address space.

The serial clock idles high and the block captures MOSI on each rising edge. For a read burst the register at the current address is loaded into an output shift register before its first bit is needed, and each following bit is presented on MISO before the rising edge that consumes it. Raising the select line ends the transfer at once; a word that was only partly received is dropped. All three SPI inputs are asynchronous to the system clock and pass through a synchroniser before edge detection, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_regbank_bridge`

## Requirements
- R1: After reset MISO is low and every register reads back as zero.
- R2: A burst whose operation byte is 0 writes each complete 32-bit word (received bit 0 first) to the register at the current address, then adds 4 to the address before the next word.
- R3: A burst whose operation byte is 1 returns the register at the current address bit 0 first, with each bit valid on MISO before the rising serial clock edge, then adds 4 to the address and returns the next register.
- R4: The address byte wraps modulo 256, so a burst started at 0xFC continues at 0x00.
- R5: Raising the select line in the middle of a word aborts the transfer: the partial word is not stored, earlier complete words stay stored, and the next select falling edge starts a fresh transaction.
- R6: An operation byte other than 0 or 1 causes no register change and keeps MISO low until the select line rises.
- R7: Serial clock and MOSI activity while the select line is high has no effect: MISO stays low and the next transaction frames from the following select falling edge.
- R8: MISO is low whenever the block is not in the data phase of a read burst, including the operation and address bytes and the whole of a write burst.
- R9: The register addressed is chosen by address bits [7:2]; bits [1:0] of the start address do not affect which register is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idles high |
| mosi_i | input | 1 | Serial data from the master |
| csn_i | input | 1 | Active-low select from the master |
| miso_o | output | 1 | Serial data to the master |

## Verification
The hardest case to reach is an abort that lands partway through a data word, because only a select rise between two word boundaries exercises the discard path while earlier words of the same burst must survive. The bench drives such bursts directly, writing one complete word and then a fraction of the next before raising select, and likewise cuts a read short before resuming with a clean transaction. Random bursts with random start addresses, lengths and directions then cross the 0xFC wrap point and unaligned start addresses alongside ordinary traffic, all compared against a register model kept in the bench.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = ADDR_W - 2;
    localparam int CNT_W    = $clog2(WORD_W);
    localparam int NUM_REGS = 1 << IDX_W;

    localparam logic [BYTE_W-1:0] OP_WRITE = 8'd0;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              is_rd;
        logic              sclk_p;
        logic              cs_p;
        logic [WORD_W-1:0] rx_sh;
        logic [WORD_W-1:0] tx_sh;
    } eng_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= din_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [WORD_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
    import spi_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s_i,
    input  logic              sclk_s_i,
    input  logic              mosi_s_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              sclk_rise_o,
    output eng_st_e           st_o,
    output logic              miso_o
);
    localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_WORD_BIT = CNT_W'(WORD_W - 1);
    localparam logic [ADDR_W-1:0] ADDR_STEP    = ADDR_W'(WORD_W / 8);

    eng_t              eng_d, eng_q;
    logic              rise;
    logic              cs_fall;
    logic [WORD_W-1:0] rx_next;
    logic [BYTE_W-1:0] byte_next;

    always_comb begin
        rise      = sclk_s_i & ~eng_q.sclk_p;
        cs_fall   = ~cs_s_i & eng_q.cs_p;
        rx_next   = {mosi_s_i, eng_q.rx_sh[WORD_W-1:1]};
        byte_next = rx_next[WORD_W-1 -: BYTE_W];

        eng_d        = eng_q;
        eng_d.sclk_p = sclk_s_i;
        eng_d.cs_p   = cs_s_i;
        wr_en_o      = 1'b0;
        rd_idx_o     = eng_q.addr[ADDR_W-1:2];

        if (cs_s_i) begin
            eng_d.st  = ST_IDLE;
            eng_d.cnt = '0;
        end else begin
            unique case (eng_q.st)
                ST_IDLE: begin
                    if (cs_fall) begin
                        eng_d.st  = ST_OPCODE;
                        eng_d.cnt = '0;
                    end
                end
                ST_OPCODE: begin
                    if (rise) begin
                        eng_d.rx_sh = rx_next;
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                        if (eng_q.cnt == LAST_BYTE_BIT) begin
                            eng_d.cnt = '0;
                            if (byte_next == OP_WRITE) begin
                                eng_d.st    = ST_ADDR;
                                eng_d.is_rd = 1'b0;
                            end else if (byte_next == OP_READ) begin
                                eng_d.st    = ST_ADDR;
                                eng_d.is_rd = 1'b1;
                            end else begin
                                eng_d.st = ST_HOLD;
                            end
                        end
                    end
                end
                ST_ADDR: begin
                    if (rise) begin
                        eng_d.rx_sh = rx_next;
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                        if (eng_q.cnt == LAST_BYTE_BIT) begin
                            eng_d.cnt  = '0;
                            eng_d.addr = byte_next;
                            if (eng_q.is_rd) begin
                                rd_idx_o    = byte_next[ADDR_W-1:2];
                                eng_d.tx_sh = rd_data_i;
                                eng_d.st    = ST_RDATA;
                            end else begin
                                eng_d.st = ST_WDATA;
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (rise) begin
                        eng_d.rx_sh = rx_next;
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                        if (eng_q.cnt == LAST_WORD_BIT) begin
                            wr_en_o    = 1'b1;
                            eng_d.addr = eng_q.addr + ADDR_STEP;
                        end
                    end
                end
                ST_RDATA: begin
                    if (rise) begin
                        eng_d.tx_sh = eng_q.tx_sh >> 1;
                        eng_d.cnt   = eng_q.cnt + 1'b1;
                        if (eng_q.cnt == LAST_WORD_BIT) begin
                            eng_d.addr  = eng_q.addr + ADDR_STEP;
                            rd_idx_o    = eng_q.addr[ADDR_W-1:2] + 1'b1;
                            eng_d.tx_sh = rd_data_i;
                        end
                    end
                end
                ST_HOLD: begin
                    eng_d.st = ST_HOLD;
                end
                default: begin
                    eng_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q        <= '0;
            eng_q.st     <= ST_IDLE;
            eng_q.sclk_p <= 1'b1;
            eng_q.cs_p   <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_addr_o   = eng_q.addr;
    assign wr_data_o   = rx_next;
    assign sclk_rise_o = rise;
    assign st_o        = eng_q.st;
    assign miso_o      = (eng_q.st == ST_RDATA) & eng_q.tx_sh[0];
endmodule

// File: rtl/spi_regbank_bridge.sv
module spi_regbank_bridge
    import spi_rb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic csn_i,
    output logic miso_o
);
    localparam int PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b110;

    logic [PIN_N-1:0]  pins_s;
    logic              cs_s;
    logic              sclk_s;
    logic              mosi_s;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic              sclk_rise;
    eng_st_e           eng_st;

    spi_rb_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({csn_i, sclk_i, mosi_i}),
        .dout_o (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_rb_engine eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s_i      (cs_s),
        .sclk_s_i    (sclk_s),
        .mosi_s_i    (mosi_s),
        .rd_data_i   (rd_data),
        .rd_idx_o    (rd_idx),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .sclk_rise_o (sclk_rise),
        .st_o        (eng_st),
        .miso_o      (miso_o)
    );

    spi_rb_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_addr[ADDR_W-1:2]),
        .wr_data_i (wr_data),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
    import spi_rb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              sclk_rise,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              miso_o,
    input eng_st_e           eng_st
);
    // R8
    idle_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_o);

    // R5
    deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !wr_en);

    // R2
    write_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sclk_rise);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == $past(wr_addr) + 8'd4));

    // R6
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_HOLD) |-> !wr_en);

    // R3
    miso_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !cs_s) |=> $stable(miso_o));
endmodule

bind spi_regbank_bridge spi_rb_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sclk_rise (sclk_rise),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .miso_o    (miso_o),
    .eng_st    (eng_st)
);

// File: tb/spi_regbank_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_regbank_bridge_tb_top;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic csn = 1'b1;
    logic miso;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [64];

    always #2.5 clk = ~clk;

    spi_regbank_bridge dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .mosi_i (mosi),
        .csn_i  (csn),
        .miso_o (miso)
    );

    function automatic int idx_of(input logic [7:0] a);
        return int'(a[7:2]);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic r);
        @(negedge clk);
        sclk = 1'b0;
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] v, output logic [7:0] r);
        for (int i = 0; i < 8; i++) xbit(v[i], r[i]);
    endtask

    task automatic xword(input logic [31:0] v, output logic [31:0] r);
        for (int i = 0; i < 32; i++) xbit(v[i], r[i]);
    endtask

    task automatic cs_on();
        @(negedge clk);
        csn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] start, input int n);
        logic [7:0]  rb;
        logic [31:0] rw;
        logic [31:0] w;
        logic [7:0]  a;
        a = start;
        cs_on();
        xbyte(8'h00, rb);
        check(rb == 8'h00, "R8 opcode byte", 32'(rb), 32'h0);
        xbyte(start, rb);
        check(rb == 8'h00, "R8 address byte", 32'(rb), 32'h0);
        for (int k = 0; k < n; k++) begin
            w = $urandom;
            xword(w, rw);
            check(rw == 32'h0, "R8 write data phase", rw, 32'h0);
            model[idx_of(a)] = w;
            a = a + 8'd4;
        end
        cs_off();
    endtask

    task automatic do_read(input logic [7:0] start, input int n, input string tag);
        logic [7:0]  rb;
        logic [31:0] rw;
        logic [7:0]  a;
        a = start;
        cs_on();
        xbyte(8'h01, rb);
        check(rb == 8'h00, "R8 opcode byte of read", 32'(rb), 32'h0);
        xbyte(start, rb);
        check(rb == 8'h00, "R8 address byte of read", 32'(rb), 32'h0);
        for (int k = 0; k < n; k++) begin
            xword($urandom, rw);
            check(rw == model[idx_of(a)], tag, rw, model[idx_of(a)]);
            a = a + 8'd4;
        end
        cs_off();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            finish_run();
        end
    end

    initial begin
        logic [7:0]  rb;
        logic [31:0] rw;
        logic        r1;
        int          seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 64; i++) model[i] = 32'h0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check(miso == 1'b0, "R1 miso after reset", 32'(miso), 32'h0);
        do_read(8'h00, 3, "R1 register after reset");
        do_read(8'hF8, 2, "R1 high register after reset");

        // R2 / R3: directed burst
        do_write(8'h00, 3);
        do_read(8'h00, 3, "R3 read back burst");

        // R4: wrap past 0xFC
        do_write(8'hFC, 2);
        do_read(8'hFC, 2, "R4 wrap read");
        do_read(8'h00, 1, "R4 wrapped word at 0x00");

        // R9: unaligned start address
        do_write(8'h13, 1);
        do_read(8'h10, 1, "R9 low address bits ignored");
        do_read(8'h12, 1, "R9 read at unaligned address");

        // R5: abort in the middle of a write word
        cs_on();
        xbyte(8'h00, rb);
        xbyte(8'h20, rb);
        rw = 32'hA5C3_0F96;
        xword(rw, rw);
        model[8] = 32'hA5C3_0F96;
        for (int i = 0; i < 13; i++) xbit(1'b1, r1);
        cs_off();
        do_read(8'h20, 2, "R5 partial word discarded");

        // R5: abort during a read, then a clean transaction
        cs_on();
        xbyte(8'h01, rb);
        xbyte(8'h24, rb);
        for (int i = 0; i < 10; i++) xbit(1'b0, r1);
        cs_off();
        do_read(8'h24, 1, "R5 transaction after read abort");
        do_write(8'h28, 1);
        do_read(8'h28, 1, "R5 write after abort");

        // R6: unsupported opcodes
        cs_on();
        xbyte(8'h02, rb);
        check(rb == 8'h00, "R6 miso during bad opcode", 32'(rb), 32'h0);
        xbyte(8'h30, rb);
        check(rb == 8'h00, "R6 miso after bad opcode", 32'(rb), 32'h0);
        xword(32'hFFFF_FFFF, rw);
        check(rw == 32'h0, "R6 miso in ignored data", rw, 32'h0);
        cs_off();
        cs_on();
        xbyte(8'hFF, rb);
        xbyte(8'h00, rb);
        xword(32'h1234_5678, rw);
        check(rw == 32'h0, "R6 miso after opcode 0xFF", rw, 32'h0);
        cs_off();
        do_read(8'h30, 1, "R6 no write from bad opcode");
        do_read(8'h00, 1, "R6 no write at address zero");

        // R7: clocking while deselected
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = 1'($urandom);
            repeat (HALF) @(negedge clk);
            check(miso == 1'b0, "R7 miso while deselected", 32'(miso), 32'h0);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        do_write(8'h40, 2);
        do_read(8'h40, 2, "R7 framing after deselected clocks");

        // R2 / R3 / R4: random bursts
        for (int t = 0; t < 24; t++) begin
            logic [7:0] a;
            int         n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 3);
            if ($urandom % 2 == 0) begin
                do_write(a, n);
                do_read(a, n, "R2 random burst read back");
            end else begin
                do_read(a, n, "R3 random read burst");
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule